// File: doc/BRIEF.md
# SMBus Block Transfer Buffer Engine

This block owns the 32-entry byte buffer used by SMBus block transfers, together with the software-visible block data port that fills and drains it. It sits between the host register unit and the bus sequencer. The register unit passes in software accesses (block data reads and writes, status writes, the mode bit, the start strobe with its direction, the last-byte flag and the byte count). The sequencer fills the buffer after a bus read, reads it out during a bus write, and reports completion or error. The engine answers with one-cycle requests to set bits in, or clear busy from, the status register held by the register unit.

There are two modes. In buffered mode software streams the whole message through the block data port, and a running index walks the buffer. In byte-at-a-time mode software moves one byte per handshake. The engine raises byte-done, software answers with a status write, and the engine advances to the next byte. In this mode the data port only touches a single holding byte. A pending flag records that a byte-at-a-time operation, or the drain of a buffered read, is still open.

Top module: `smb_blkbuf_engine`

## Requirements
- R1: The index wraps to 0 before use whenever a block data access finds it at 32 or higher.
- R2: In buffered mode a block data write stores the byte at the index, and a block data read returns the byte at the index. Both then advance the index by one.
- R3: A buffered read requests interrupt (status bit 1) in the cycle the sequencer reports the read done, and opens a pending drain with the index at 0. The block data read whose advanced index equals the count closes the drain, resets the index and requests busy clear. Later reads request nothing.
- R4: A buffered write start with the index equal to the count pulses the go-write request. When the sequencer then reports done, the engine requests interrupt and busy clear. A start with a different index requests device error (status bit 2), issues no go-write and resets the index.
- R5: A byte-at-a-time write start copies the holding byte into entry 0, sets the index to 0, opens the pending flag and requests busy (bit 0) with byte-done (bit 3).
- R6: In a pending byte-at-a-time write, each status write advances the index. If the new index equals the count, the engine pulses go-write, and a later done requests interrupt with busy clear. Otherwise it stores the holding byte at the new index and requests byte-done.
- R7: A byte-at-a-time read done loads entry 0 into the holding byte and requests busy with byte-done. Each status write advances the index. With the last-byte flag set, the engine presents the byte at the new index, requests interrupt and busy clear, and ends the operation. Without the flag, it presents that byte and requests byte-done.
- R8: In byte-at-a-time mode a block data write only latches the holding byte and leaves the buffer unchanged. A block data read returns the holding byte.
- R9: After reset the mode equals the force-buffered input (1 = buffered). A mode write replaces the mode.
- R10: A start abandons any open operation and restarts at index 0. A sequencer completion arriving in the same cycle as a start is dropped.
- R11: A status write with no pending byte-at-a-time operation only clears status bits in the register unit. It issues no request, and neither the index nor the buffer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| force_buffered_i | input | 1 | Mode loaded at reset (1 = buffered) |
| aux_wr_i | input | 1 | Software write of the mode bit |
| aux_buffered_i | input | 1 | Mode value written |
| bd_wr_i | input | 1 | Block data port write |
| bd_rd_i | input | 1 | Block data port read |
| bd_wdata_i | input | 8 | Block data write value |
| bd_rdata_o | output | 8 | Block data read value |
| sts_wr_i | input | 1 | Software write of the status register |
| start_i | input | 1 | Start of a block operation |
| start_read_i | input | 1 | Direction of the start (1 = read) |
| last_byte_i | input | 1 | Last-byte flag from control |
| count_i | input | 8 | Byte count from data0 |
| sts_set_o | output | 4 | Status set request: bit3 byte-done, bit2 device error, bit1 interrupt, bit0 busy |
| sts_clr_busy_o | output | 1 | Busy clear request |
| buffered_o | output | 1 | Current mode |
| seq_go_wr_o | output | 1 | Request the sequencer to run the bus write |
| seq_wr_done_i | input | 1 | Bus write finished |
| seq_wr_err_i | input | 1 | Bus write failed |
| seq_rd_done_i | input | 1 | Bus read finished, buffer filled |
| seq_rd_err_i | input | 1 | Bus read failed |
| buf_we_i | input | 1 | Sequencer buffer write |
| buf_waddr_i | input | 5 | Sequencer write address |
| buf_wdata_i | input | 8 | Sequencer write data |
| buf_raddr_i | input | 5 | Sequencer read address |
| buf_rdata_o | output | 8 | Sequencer read data |

## Verification
Two events can fall in the same cycle: a start and the sequencer's completion of the operation that start abandons. The bench lets a byte-at-a-time write reach its go-write. It then drives the write-done pulse in the same cycle as a new read start. The check is that no interrupt or busy-clear request appears in that cycle, and that the following read done is handled as a fresh byte-at-a-time read.

// File: rtl/smb_bb_pkg.sv
package smb_bb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_RD = 2'd1,
        ST_WAIT_WR = 2'd2
    } bb_state_t;

    // status request bits, MSB first: bit3 .. bit0
    typedef struct packed {
        logic byte_done;
        logic dev_err;
        logic intr;
        logic busy;
    } sts_req_t;

    localparam sts_req_t STS_NONE = '{byte_done: 1'b0, dev_err: 1'b0, intr: 1'b0, busy: 1'b0};

    function automatic sts_req_t sts_req(input logic bd, input logic de,
                                         input logic it, input logic bz);
        sts_req_t r;
        r.byte_done = bd;
        r.dev_err   = de;
        r.intr      = it;
        r.busy      = bz;
        return r;
    endfunction

endpackage

// File: rtl/smb_bb_buffer.sv
module smb_bb_buffer #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int NRD   = 3,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    a_we,
    input  logic [AW-1:0]           a_addr,
    input  logic [DW-1:0]           a_data,
    input  logic                    b_we,
    input  logic [AW-1:0]           b_addr,
    input  logic [DW-1:0]           b_data,
    input  logic [NRD-1:0][AW-1:0]  rd_addr,
    output logic [NRD-1:0][DW-1:0]  rd_data
);

    logic [DW-1:0] mem_q [DEPTH];

    // port A (engine side) wins over port B (sequencer) on the same entry
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (b_we) mem_q[b_addr] <= b_data;
            if (a_we) mem_q[a_addr] <= a_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = mem_q[rd_addr[p]];
    end

endmodule

// File: rtl/smb_bb_ctrl.sv
module smb_bb_ctrl
    import smb_bb_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int CW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int IW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          force_buffered_i,
    input  logic          aux_wr_i,
    input  logic          aux_buffered_i,
    input  logic          bd_wr_i,
    input  logic          bd_rd_i,
    input  logic [DW-1:0] bd_wdata_i,
    output logic [DW-1:0] bd_rdata_o,
    input  logic          sts_wr_i,
    input  logic          start_i,
    input  logic          start_read_i,
    input  logic          last_byte_i,
    input  logic [CW-1:0] count_i,
    output sts_req_t      sts_set_o,
    output logic          sts_clr_busy_o,
    output logic          buffered_o,
    output logic          seq_go_wr_o,
    input  logic          seq_wr_done_i,
    input  logic          seq_wr_err_i,
    input  logic          seq_rd_done_i,
    input  logic          seq_rd_err_i,
    output logic          sw_we_o,
    output logic [AW-1:0] sw_waddr_o,
    output logic [DW-1:0] sw_wdata_o,
    output logic [AW-1:0] cur_raddr_o,
    output logic [AW-1:0] nxt_raddr_o,
    input  logic [DW-1:0] cur_rdata_i,
    input  logic [DW-1:0] nxt_rdata_i
);

    bb_state_t     state_q, state_d;
    logic          pend_q, pend_d;
    logic          dir_rd_q, dir_rd_d;
    logic          buffered_q, buffered_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [DW-1:0] hold_q, hold_d;

    logic [IW-1:0] widx, widx_n, idx_n;
    logic          rd_fin;

    assign widx   = (idx_q >= IW'(DEPTH)) ? '0 : idx_q;
    assign widx_n = widx + 1'b1;
    assign idx_n  = idx_q + 1'b1;
    assign rd_fin = (state_q == ST_WAIT_RD) && (seq_rd_done_i || seq_rd_err_i);

    assign cur_raddr_o = widx[AW-1:0];
    assign nxt_raddr_o = rd_fin ? '0 : idx_n[AW-1:0];
    assign bd_rdata_o  = buffered_q ? cur_rdata_i : hold_q;
    assign buffered_o  = buffered_q;

    always_comb begin
        state_d        = state_q;
        pend_d         = pend_q;
        dir_rd_d       = dir_rd_q;
        buffered_d     = buffered_q;
        idx_d          = idx_q;
        hold_d         = hold_q;
        sts_set_o      = STS_NONE;
        sts_clr_busy_o = 1'b0;
        seq_go_wr_o    = 1'b0;
        sw_we_o        = 1'b0;
        sw_waddr_o     = widx[AW-1:0];
        sw_wdata_o     = bd_wdata_i;

        if (aux_wr_i) buffered_d = aux_buffered_i;

        // software block data port
        if (bd_wr_i) begin
            if (buffered_q) begin
                sw_we_o = 1'b1;
                idx_d   = widx_n;
            end else begin
                hold_d = bd_wdata_i;
            end
        end
        if (bd_rd_i && buffered_q) begin
            idx_d = widx_n;
            if (pend_q && (CW'(widx_n) == count_i)) begin
                pend_d         = 1'b0;
                idx_d          = '0;
                sts_clr_busy_o = 1'b1;
            end
        end

        // byte-at-a-time handshake
        if (sts_wr_i && !buffered_q && pend_q && state_q == ST_IDLE) begin
            if (!dir_rd_q) begin
                idx_d = idx_n;
                if (CW'(idx_n) == count_i) begin
                    seq_go_wr_o = 1'b1;
                    state_d     = ST_WAIT_WR;
                end else begin
                    sw_we_o    = 1'b1;
                    sw_waddr_o = idx_n[AW-1:0];
                    sw_wdata_o = hold_q;
                    sts_set_o  = sts_req(1'b1, 1'b0, 1'b0, 1'b0);
                end
            end else begin
                hold_d = nxt_rdata_i;
                if (last_byte_i) begin
                    idx_d          = '0;
                    pend_d         = 1'b0;
                    sts_set_o      = sts_req(1'b0, 1'b0, 1'b1, 1'b0);
                    sts_clr_busy_o = 1'b1;
                end else begin
                    idx_d     = idx_n;
                    sts_set_o = sts_req(1'b1, 1'b0, 1'b0, 1'b0);
                end
            end
        end

        // sequencer completions
        if (state_q == ST_WAIT_WR && (seq_wr_done_i || seq_wr_err_i)) begin
            state_d = ST_IDLE;
            pend_d  = 1'b0;
            if (seq_wr_err_i) begin
                sts_set_o = sts_req(1'b0, 1'b1, 1'b0, 1'b0);
            end else begin
                sts_set_o      = sts_req(1'b0, 1'b0, 1'b1, 1'b0);
                sts_clr_busy_o = 1'b1;
            end
        end
        if (rd_fin) begin
            state_d = ST_IDLE;
            idx_d   = '0;
            if (seq_rd_err_i) begin
                pend_d    = 1'b0;
                sts_set_o = sts_req(1'b0, 1'b1, 1'b0, 1'b0);
            end else if (buffered_q) begin
                pend_d    = 1'b1;
                sts_set_o = sts_req(1'b0, 1'b0, 1'b1, 1'b0);
            end else begin
                pend_d    = 1'b1;
                hold_d    = nxt_rdata_i;
                sts_set_o = sts_req(1'b1, 1'b0, 1'b0, 1'b1);
            end
        end

        // start overrides everything above
        if (start_i) begin
            sts_set_o      = STS_NONE;
            sts_clr_busy_o = 1'b0;
            seq_go_wr_o    = 1'b0;
            pend_d         = 1'b0;
            idx_d          = '0;
            state_d        = ST_IDLE;
            dir_rd_d       = start_read_i;
            if (start_read_i) begin
                state_d = ST_WAIT_RD;
            end else if (buffered_q) begin
                if (CW'(idx_q) == count_i) begin
                    seq_go_wr_o = 1'b1;
                    state_d     = ST_WAIT_WR;
                end else begin
                    sts_set_o = sts_req(1'b0, 1'b1, 1'b0, 1'b0);
                end
            end else begin
                sw_we_o    = 1'b1;
                sw_waddr_o = '0;
                sw_wdata_o = hold_q;
                pend_d     = 1'b1;
                sts_set_o  = sts_req(1'b1, 1'b0, 1'b0, 1'b1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            pend_q     <= 1'b0;
            dir_rd_q   <= 1'b0;
            buffered_q <= force_buffered_i;
            idx_q      <= '0;
            hold_q     <= '0;
        end else begin
            state_q    <= state_d;
            pend_q     <= pend_d;
            dir_rd_q   <= dir_rd_d;
            buffered_q <= buffered_d;
            idx_q      <= idx_d;
            hold_q     <= hold_d;
        end
    end

    AST_START_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (idx_q == '0)); // R10
    AST_GO_ENTERS_WAIT: assert property (@(posedge clk) disable iff (rst)
        seq_go_wr_o |=> (state_q == ST_WAIT_WR)); // R4
    AST_NO_INTR_WITH_ERR: assert property (@(posedge clk) disable iff (rst)
        !(sts_set_o.intr && sts_set_o.dev_err)); // R4
    AST_CLR_BUSY_CLOSES: assert property (@(posedge clk) disable iff (rst)
        sts_clr_busy_o |=> !pend_q); // R3
    AST_BYTE_DONE_PENDING: assert property (@(posedge clk) disable iff (rst)
        sts_set_o.byte_done |=> pend_q); // R7

endmodule

// File: rtl/smb_blkbuf_engine.sv
module smb_blkbuf_engine
    import smb_bb_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int CW    = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     force_buffered_i,
    input  logic                     aux_wr_i,
    input  logic                     aux_buffered_i,
    input  logic                     bd_wr_i,
    input  logic                     bd_rd_i,
    input  logic [DW-1:0]            bd_wdata_i,
    output logic [DW-1:0]            bd_rdata_o,
    input  logic                     sts_wr_i,
    input  logic                     start_i,
    input  logic                     start_read_i,
    input  logic                     last_byte_i,
    input  logic [CW-1:0]            count_i,
    output logic [3:0]               sts_set_o,
    output logic                     sts_clr_busy_o,
    output logic                     buffered_o,
    output logic                     seq_go_wr_o,
    input  logic                     seq_wr_done_i,
    input  logic                     seq_wr_err_i,
    input  logic                     seq_rd_done_i,
    input  logic                     seq_rd_err_i,
    input  logic                     buf_we_i,
    input  logic [$clog2(DEPTH)-1:0] buf_waddr_i,
    input  logic [DW-1:0]            buf_wdata_i,
    input  logic [$clog2(DEPTH)-1:0] buf_raddr_i,
    output logic [DW-1:0]            buf_rdata_o
);

    localparam int AW  = $clog2(DEPTH);
    localparam int NRD = 3;

    sts_req_t               set_req;
    logic                   sw_we;
    logic [AW-1:0]          sw_waddr, cur_raddr, nxt_raddr;
    logic [DW-1:0]          sw_wdata;
    logic [NRD-1:0][AW-1:0] rd_addr;
    logic [NRD-1:0][DW-1:0] rd_data;

    assign rd_addr     = {buf_raddr_i, nxt_raddr, cur_raddr};
    assign buf_rdata_o = rd_data[2];
    assign sts_set_o   = set_req;

    smb_bb_buffer #(.DEPTH(DEPTH), .DW(DW), .NRD(NRD)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .a_we    (sw_we),
        .a_addr  (sw_waddr),
        .a_data  (sw_wdata),
        .b_we    (buf_we_i),
        .b_addr  (buf_waddr_i),
        .b_data  (buf_wdata_i),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    smb_bb_ctrl #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_ctrl (
        .clk              (clk),
        .rst              (rst),
        .force_buffered_i (force_buffered_i),
        .aux_wr_i         (aux_wr_i),
        .aux_buffered_i   (aux_buffered_i),
        .bd_wr_i          (bd_wr_i),
        .bd_rd_i          (bd_rd_i),
        .bd_wdata_i       (bd_wdata_i),
        .bd_rdata_o       (bd_rdata_o),
        .sts_wr_i         (sts_wr_i),
        .start_i          (start_i),
        .start_read_i     (start_read_i),
        .last_byte_i      (last_byte_i),
        .count_i          (count_i),
        .sts_set_o        (set_req),
        .sts_clr_busy_o   (sts_clr_busy_o),
        .buffered_o       (buffered_o),
        .seq_go_wr_o      (seq_go_wr_o),
        .seq_wr_done_i    (seq_wr_done_i),
        .seq_wr_err_i     (seq_wr_err_i),
        .seq_rd_done_i    (seq_rd_done_i),
        .seq_rd_err_i     (seq_rd_err_i),
        .sw_we_o          (sw_we),
        .sw_waddr_o       (sw_waddr),
        .sw_wdata_o       (sw_wdata),
        .cur_raddr_o      (cur_raddr),
        .nxt_raddr_o      (nxt_raddr),
        .cur_rdata_i      (rd_data[0]),
        .nxt_rdata_i      (rd_data[1])
    );

endmodule

// File: tb/smb_blkbuf_engine_tb.sv
module smb_blkbuf_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       force_buffered_i = 1'b1;
    logic       aux_wr_i = 0, aux_buffered_i = 0;
    logic       bd_wr_i = 0, bd_rd_i = 0;
    logic [7:0] bd_wdata_i = 0;
    logic [7:0] bd_rdata_o;
    logic       sts_wr_i = 0, start_i = 0, start_read_i = 0, last_byte_i = 0;
    logic [7:0] count_i = 0;
    logic [3:0] sts_set_o;
    logic       sts_clr_busy_o, buffered_o, seq_go_wr_o;
    logic       seq_wr_done_i = 0, seq_wr_err_i = 0, seq_rd_done_i = 0, seq_rd_err_i = 0;
    logic       buf_we_i = 0;
    logic [4:0] buf_waddr_i = 0, buf_raddr_i = 0;
    logic [7:0] buf_wdata_i = 0;
    logic [7:0] buf_rdata_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    smb_blkbuf_engine dut_i (
        .clk(clk), .rst(rst), .force_buffered_i(force_buffered_i),
        .aux_wr_i(aux_wr_i), .aux_buffered_i(aux_buffered_i),
        .bd_wr_i(bd_wr_i), .bd_rd_i(bd_rd_i), .bd_wdata_i(bd_wdata_i),
        .bd_rdata_o(bd_rdata_o), .sts_wr_i(sts_wr_i), .start_i(start_i),
        .start_read_i(start_read_i), .last_byte_i(last_byte_i), .count_i(count_i),
        .sts_set_o(sts_set_o), .sts_clr_busy_o(sts_clr_busy_o), .buffered_o(buffered_o),
        .seq_go_wr_o(seq_go_wr_o), .seq_wr_done_i(seq_wr_done_i), .seq_wr_err_i(seq_wr_err_i),
        .seq_rd_done_i(seq_rd_done_i), .seq_rd_err_i(seq_rd_err_i),
        .buf_we_i(buf_we_i), .buf_waddr_i(buf_waddr_i), .buf_wdata_i(buf_wdata_i),
        .buf_raddr_i(buf_raddr_i), .buf_rdata_o(buf_rdata_o)
    );

    // buffered drain table: {expected byte, expected busy clear}
    localparam logic [8:0] DRAIN_TBL [4] = '{
        {8'hC0, 1'b0}, {8'hC1, 1'b0}, {8'hC2, 1'b0}, {8'hC3, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // advance to next negedge and drop all strobes
    task automatic nxt();
        @(negedge clk);
        aux_wr_i = 0; bd_wr_i = 0; bd_rd_i = 0; sts_wr_i = 0; start_i = 0;
        seq_wr_done_i = 0; seq_wr_err_i = 0; seq_rd_done_i = 0; seq_rd_err_i = 0;
        buf_we_i = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R9 reset mode", buffered_o, 1);
        chk("R9 reset requests", {sts_set_o, sts_clr_busy_o, seq_go_wr_o}, 0);

        // R2/R4: buffered fill then matching start
        for (int i = 0; i < 5; i++) begin
            nxt(); bd_wr_i = 1; bd_wdata_i = 8'hA0 + 8'(i);
        end
        nxt(); count_i = 5; start_i = 1; start_read_i = 0; #1;
        chk("R4 go on match", seq_go_wr_o, 1);
        chk("R4 no status at go", sts_set_o, 0);
        nxt(); buf_raddr_i = 2; #1;
        chk("R2 buffered store", buf_rdata_o, 8'hA2);
        seq_wr_done_i = 1; #1;
        chk("R4 done intr", sts_set_o, 4'b0010);
        chk("R4 done busy clr", sts_clr_busy_o, 1);

        // R4 mismatch
        nxt(); bd_wr_i = 1; bd_wdata_i = 8'h51;
        nxt(); bd_wr_i = 1; bd_wdata_i = 8'h52;
        nxt(); count_i = 3; start_i = 1; start_read_i = 0; #1;
        chk("R4 mismatch dev err", sts_set_o, 4'b0100);
        chk("R4 mismatch no go", seq_go_wr_o, 0);
        nxt(); bd_wr_i = 1; bd_wdata_i = 8'h77;
        nxt(); buf_raddr_i = 0; #1;
        chk("R4 index reset", buf_rdata_o, 8'h77);

        // R1 wrap
        for (int i = 1; i < 32; i++) begin
            nxt(); bd_wr_i = 1; bd_wdata_i = 8'(i);
        end
        nxt(); bd_wr_i = 1; bd_wdata_i = 8'hEE;
        nxt(); buf_raddr_i = 0; #1;
        chk("R1 wrap to 0", buf_rdata_o, 8'hEE);
        buf_raddr_i = 31; #1;
        chk("R1 last entry", buf_rdata_o, 8'h1F);

        // R3 buffered read
        nxt(); count_i = 4; start_i = 1; start_read_i = 1; #1;
        chk("R3 read start quiet", sts_set_o, 0);
        for (int i = 0; i < 4; i++) begin
            nxt(); buf_we_i = 1; buf_waddr_i = 5'(i); buf_wdata_i = 8'hC0 + 8'(i);
        end
        nxt(); seq_rd_done_i = 1; #1;
        chk("R3 read done intr", sts_set_o, 4'b0010);
        chk("R3 read done no clr", sts_clr_busy_o, 0);
        for (int i = 0; i < 4; i++) begin
            nxt(); bd_rd_i = 1; #1;
            chk("R2 drain byte", bd_rdata_o, DRAIN_TBL[i][8:1]);
            chk("R3 drain busy clr", sts_clr_busy_o, DRAIN_TBL[i][0]);
        end
        nxt(); bd_rd_i = 1; #1;
        chk("R3 index back to 0", bd_rdata_o, 8'hC0);
        chk("R3 closed no clr", sts_clr_busy_o, 0);

        // R9 mode write, R8 holding byte
        nxt(); aux_wr_i = 1; aux_buffered_i = 0;
        nxt(); #1;
        chk("R9 mode write", buffered_o, 0);
        bd_wr_i = 1; bd_wdata_i = 8'h11;
        nxt(); buf_raddr_i = 1; #1;
        chk("R8 holding read", bd_rdata_o, 8'h11);
        chk("R8 buffer untouched", buf_rdata_o, 8'hC1);

        // R5/R6 byte write, count 3
        count_i = 3; start_i = 1; start_read_i = 0; #1;
        chk("R5 start busy+byte done", sts_set_o, 4'b1001);
        nxt(); buf_raddr_i = 0; #1;
        chk("R5 first byte", buf_rdata_o, 8'h11);
        bd_wr_i = 1; bd_wdata_i = 8'h22;
        nxt(); sts_wr_i = 1; #1;
        chk("R6 advance byte done", sts_set_o, 4'b1000);
        nxt(); buf_raddr_i = 1; #1;
        chk("R6 stored byte 1", buf_rdata_o, 8'h22);
        bd_wr_i = 1; bd_wdata_i = 8'h33;
        nxt(); sts_wr_i = 1; #1;
        chk("R6 advance 2", sts_set_o, 4'b1000);
        nxt(); buf_raddr_i = 2; #1;
        chk("R6 stored byte 2", buf_rdata_o, 8'h33);
        sts_wr_i = 1; #1;
        chk("R6 go at count", seq_go_wr_o, 1);
        nxt(); seq_wr_done_i = 1; #1;
        chk("R6 done intr", sts_set_o, 4'b0010);
        chk("R6 done clr", sts_clr_busy_o, 1);
        nxt(); sts_wr_i = 1; #1;
        chk("R11 idle status write", {sts_set_o, sts_clr_busy_o, seq_go_wr_o}, 0);

        // R7 byte read
        nxt(); count_i = 0; start_i = 1; start_read_i = 1;
        for (int i = 0; i < 3; i++) begin
            nxt(); buf_we_i = 1; buf_waddr_i = 5'(i); buf_wdata_i = 8'hD0 + 8'(i);
        end
        nxt(); seq_rd_done_i = 1; #1;
        chk("R7 read done", sts_set_o, 4'b1001);
        nxt(); #1;
        chk("R7 first byte", bd_rdata_o, 8'hD0);
        sts_wr_i = 1; last_byte_i = 0; #1;
        chk("R7 advance", sts_set_o, 4'b1000);
        nxt(); #1;
        chk("R7 second byte", bd_rdata_o, 8'hD1);
        sts_wr_i = 1; last_byte_i = 1; #1;
        chk("R7 last intr", sts_set_o, 4'b0010);
        chk("R7 last clr", sts_clr_busy_o, 1);
        nxt(); last_byte_i = 0; #1;
        chk("R7 last byte", bd_rdata_o, 8'hD2);
        sts_wr_i = 1; #1;
        chk("R11 after read end", {sts_set_o, sts_clr_busy_o}, 0);

        // R10 abandon and same-cycle completion
        nxt(); bd_wr_i = 1; bd_wdata_i = 8'h61;
        nxt(); count_i = 3; start_i = 1; start_read_i = 0;
        nxt(); sts_wr_i = 1;
        nxt(); count_i = 1; start_i = 1; start_read_i = 0; #1;
        chk("R10 restart", sts_set_o, 4'b1001);
        nxt(); sts_wr_i = 1; #1;
        chk("R10 index restarted", seq_go_wr_o, 1);
        nxt(); seq_wr_done_i = 1; start_i = 1; start_read_i = 1; #1;
        chk("R10 done dropped", {sts_set_o, sts_clr_busy_o}, 0);
        nxt(); seq_rd_done_i = 1; #1;
        chk("R10 new read runs", sts_set_o, 4'b1001);

        nxt();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule